// File: doc/BRIEF.md
# UART Receive Buffer with Switchable Depth

This block is the receive-side store of a serial port. A deserializer, or a loopback path, offers one 12-bit entry at a time: eight data bits and four status bits above them. Software reads the data register, which pops the head entry and copies its four status bits into a small receive-status register. The buffer behaves as a single holding register while the FIFO-enable control bit is low. While the bit is high it behaves as a power-of-two queue of `DEPTH` entries.

A two-state mode machine follows the enable bit. Its states are MODE_SINGLE and MODE_DEEP. The ENABLE transition goes from MODE_SINGLE to MODE_DEEP and the DISABLE transition goes back. Either transition flushes the buffer in the cycle it is taken. The block offers empty and full flags, a ready signal back to the receiver, a receive-level interrupt with a trigger level of one entry, and a one-cycle overrun strobe for a push that found no room. A received line break is stored as a dedicated entry.

Top module: `uart_rxq`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `rx_ready`=1, `rx_irq`=0, `overrun`=0 and `rsr`=0.
- R2: With `fifo_en`=0 the depth is one. One push sets `full` and clears `rx_ready`. A further push is dropped, and the stored entry stays unchanged.
- R3: With `fifo_en`=1 the buffer holds `DEPTH` (16) entries and returns them in push order. `full` rises on the push that fills the last slot.
- R4: A push that finds the buffer full is discarded, and `overrun` is high for exactly the following cycle.
- R5: `pop_data` always shows the head entry. A pop removes the head and sets `empty` once the last entry has been removed. A pop while empty changes neither the count nor the flags.
- R6: In the cycle after any change of `fifo_en`, the buffer is empty, `full`=0 and `rx_ready`=1. A push or pop in the cycle of the change is ignored.
- R7: A pop loads bits 11:8 of the popped entry into `rsr`. `rsr_clr` clears `rsr` and wins over a load in the same cycle.
- R8: A push with `push_break`=1 stores 12'h400 (bit 10 set, data zero) whatever `push_data` holds, so popping it makes `rsr`=4'h4.
- R9: `rx_irq` is set by a push that brings the count to 1. It is cleared by a pop that leaves the count at 0, including a pop while empty. A flush does not change it.
- R10: A push and a pop in the same cycle both take effect when the buffer is not full. When the buffer is full, the push is dropped with an overrun even if a pop occurs in that cycle.
- R11: The read and write positions wrap modulo the current depth, so repeated push/pop traffic beyond 16 entries keeps FIFO order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single-entry mode |
| push_valid | input | 1 | Offer one entry from the receiver |
| push_break | input | 1 | Qualifies a push as a line break |
| push_data | input | 12 | Entry: status in 11:8, data in 7:0 |
| pop | input | 1 | Data-register read strobe |
| pop_data | output | 12 | Head entry |
| rsr_clr | input | 1 | Write strobe to the receive-status register (clears it) |
| rsr | output | 4 | Receive status of the last popped entry |
| empty | output | 1 | Buffer holds no entry |
| full | output | 1 | Buffer holds as many entries as the current depth |
| rx_ready | output | 1 | Count is below the current depth |
| rx_irq | output | 1 | Receive-level interrupt |
| overrun | output | 1 | One-cycle pulse for a dropped push |

## Verification
The queue is exercised with lone pushes and pops in single-entry mode, where the second push separates a depth-of-one store from a deeper one. A fill to sixteen entries followed by a seventeenth push shows where `full` and the overrun fall. Interleaved push/pop runs that cross the slot boundary more than once reveal index wrap errors through out-of-order data. Same-cycle push and pop, mode toggles with traffic present, and break pushes carrying nonzero data show the priority rules, the flush and the forced break entry.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
    localparam int ENTRY_W = 12;
    localparam int DATA_W  = 8;
    localparam int STAT_W  = ENTRY_W - DATA_W;
    localparam int BRK_BIT = 10;

    typedef logic [ENTRY_W-1:0] rxq_entry_t;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_DEEP   = 1'b1
    } rxq_mode_e;

    localparam rxq_entry_t BREAK_ENTRY = rxq_entry_t'(1) << BRK_BIT;
endpackage

// File: rtl/rxq_mode_ctl.sv
module rxq_mode_ctl
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    output logic             flush,
    output logic [PTR_W-1:0] idx_mask,
    output logic [CNT_W-1:0] depth_lim
);
    rxq_mode_e state_q, state_d;

    // next-state: ENABLE and DISABLE transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_SINGLE: if (fifo_en)  state_d = MODE_DEEP;
            MODE_DEEP:   if (!fifo_en) state_d = MODE_SINGLE;
            default:     state_d = MODE_SINGLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_SINGLE;
        else        state_q <= state_d;
    end

    // outputs of the current state
    always_comb begin
        flush = (state_d != state_q);
        unique case (state_q)
            MODE_DEEP: begin
                idx_mask  = PTR_W'(DEPTH - 1);
                depth_lim = CNT_W'(DEPTH);
            end
            default: begin
                idx_mask  = '0;
                depth_lim = CNT_W'(1);
            end
        endcase
    end
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [PTR_W-1:0] idx_mask,
    input  logic [CNT_W-1:0] depth_lim,
    input  logic             push_valid,
    input  logic             pop,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] rd_idx,
    output logic             pop_ok,
    output logic             empty,
    output logic             full,
    output logic             rx_ready,
    output logic             rx_irq,
    output logic             overrun
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PTR_W-1:0] rd_q, rd_d;
    logic             empty_q, full_q, irq_q, ovr_q;
    logic             act_push, room, take;

    always_comb begin
        act_push = push_valid && !flush;
        pop_ok   = pop && !flush;
        room     = cnt_q < depth_lim;
        wr_en    = act_push && room;
        take     = pop_ok && (cnt_q != '0);
        wr_idx   = (rd_q + cnt_q[PTR_W-1:0]) & idx_mask;
        rd_d     = take ? ((rd_q + PTR_W'(1)) & idx_mask) : rd_q;
        cnt_d    = cnt_q + CNT_W'(wr_en) - CNT_W'(take);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rd_q    <= '0;
            empty_q <= 1'b1;
            full_q  <= 1'b0;
            irq_q   <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (flush) begin
            cnt_q   <= '0;
            rd_q    <= '0;
            empty_q <= 1'b1;
            full_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            rd_q  <= rd_d;
            ovr_q <= act_push && !room;
            if (wr_en)                        empty_q <= 1'b0;
            if (pop_ok && cnt_d == '0)        empty_q <= 1'b1;
            if (pop_ok)                       full_q  <= 1'b0;
            if (wr_en && cnt_d == depth_lim)  full_q  <= 1'b1;
            if (wr_en && cnt_d == CNT_W'(1))  irq_q   <= 1'b1;
            else if (pop_ok && cnt_d == '0)   irq_q   <= 1'b0;
        end
    end

    assign rd_idx   = rd_q;
    assign empty    = empty_q;
    assign full     = full_q;
    assign rx_ready = cnt_q < depth_lim;
    assign rx_irq   = irq_q;
    assign overrun  = ovr_q;
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  rxq_entry_t       wr_entry,
    input  logic [PTR_W-1:0] rd_idx,
    output rxq_entry_t       rd_entry
);
    rxq_entry_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && wr_idx == PTR_W'(g))
                slot_q[g] <= wr_entry;
        end
    end

    assign rd_entry = slot_q[rd_idx];
endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import uart_rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [STAT_W-1:0] stat_in,
    output logic [STAT_W-1:0] stat_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    stat_q <= '0;
        else if (clr)  stat_q <= '0;
        else if (load) stat_q <= stat_in;
    end
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_en,
    input  logic        push_valid,
    input  logic        push_break,
    input  logic [11:0] push_data,
    input  logic        pop,
    output logic [11:0] pop_data,
    input  logic        rsr_clr,
    output logic [3:0]  rsr,
    output logic        empty,
    output logic        full,
    output logic        rx_ready,
    output logic        rx_irq,
    output logic        overrun
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic             flush;
    logic [PTR_W-1:0] idx_mask, wr_idx, rd_idx;
    logic [CNT_W-1:0] depth_lim;
    logic             wr_en, pop_ok;
    rxq_entry_t       wr_entry, head;

    assign wr_entry = push_break ? BREAK_ENTRY : rxq_entry_t'(push_data);

    rxq_mode_ctl #(.DEPTH(DEPTH)) u_mode (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .flush(flush), .idx_mask(idx_mask), .depth_lim(depth_lim)
    );

    rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .idx_mask(idx_mask), .depth_lim(depth_lim),
        .push_valid(push_valid), .pop(pop),
        .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx), .pop_ok(pop_ok),
        .empty(empty), .full(full), .rx_ready(rx_ready),
        .rx_irq(rx_irq), .overrun(overrun)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_entry(wr_entry), .rd_idx(rd_idx), .rd_entry(head)
    );

    rxq_status u_stat (
        .clk(clk), .rst_n(rst_n), .clr(rsr_clr), .load(pop_ok),
        .stat_in(head[ENTRY_W-1:DATA_W]), .stat_q(rsr)
    );

    assign pop_data = head;
endmodule

// File: rtl/uart_rxq_checker.sv
module uart_rxq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       flush,
    input logic       push_valid,
    input logic       pop,
    input logic       rsr_clr,
    input logic [3:0] rsr,
    input logic       empty,
    input logic       full,
    input logic       rx_ready,
    input logic       rx_irq,
    input logic       overrun
);
    assert_full_blocks_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !rx_ready);

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    assert_overrun_needs_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(full));

    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !full && rx_ready));

    assert_rsr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsr_clr |=> (rsr == 4'h0));

    assert_irq_rise_has_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> !empty);

    assert_empty_pop_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push_valid && !flush) |=> empty);
endmodule

bind uart_rxq uart_rxq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push_valid(push_valid),
    .pop(pop), .rsr_clr(rsr_clr), .rsr(rsr), .empty(empty), .full(full),
    .rx_ready(rx_ready), .rx_irq(rx_irq), .overrun(overrun)
);

// File: tb/uart_rxq_bench.sv
`timescale 1ns/1ps
module uart_rxq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0;
    logic        push_valid = 1'b0;
    logic        push_break = 1'b0;
    logic [11:0] push_data = '0;
    logic        pop = 1'b0;
    logic        rsr_clr = 1'b0;
    logic [11:0] pop_data;
    logic [3:0]  rsr;
    logic        empty, full, rx_ready, rx_irq, overrun;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit in_flush = 1'b0;

    logic [11:0] sb_q[$];
    int          exp_depth = 1;
    logic        exp_irq = 1'b0;
    logic [3:0]  exp_rsr = 4'h0;

    always #2 clk = ~clk;

    uart_rxq u_uart_rxq (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .push_valid(push_valid), .push_break(push_break), .push_data(push_data),
        .pop(pop), .pop_data(pop_data), .rsr_clr(rsr_clr), .rsr(rsr),
        .empty(empty), .full(full), .rx_ready(rx_ready),
        .rx_irq(rx_irq), .overrun(overrun)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares the head against the scoreboard on each pop
    always @(negedge clk) begin
        #1;
        if (rst_n && pop && !in_flush) begin
            if (sb_q.size() > 0) begin
                logic [11:0] e;
                e = sb_q.pop_front();
                chk("R5 pop order", 32'(pop_data), 32'(e));
                exp_rsr = e[11:8];
            end else begin
                exp_rsr = pop_data[11:8];
            end
        end
    end

    task automatic flags(input string tag, input logic ovr_exp);
        chk({tag, " empty"},   32'(empty),    32'(sb_q.size() == 0));
        chk({tag, " full"},    32'(full),     32'(sb_q.size() == exp_depth));
        chk({tag, " ready"},   32'(rx_ready), 32'(sb_q.size() < exp_depth));
        chk({tag, " overrun"}, 32'(overrun),  32'(ovr_exp));
        chk({tag, " R9 irq"},  32'(rx_irq),   32'(exp_irq));
        chk({tag, " R7 rsr"},  32'(rsr),      32'(exp_rsr));
    endtask

    task automatic cyc(input logic pv, input logic pb, input logic [11:0] pd,
                       input logic pp, input logic cl, input string tag);
        int pre;
        logic acc;
        @(negedge clk);
        push_valid = pv; push_break = pb; push_data = pd; pop = pp; rsr_clr = cl;
        pre = sb_q.size();
        @(posedge clk);
        acc = pv && (pre < exp_depth);
        if (acc) sb_q.push_back(pb ? 12'h400 : pd);
        if (acc && sb_q.size() == 1) exp_irq = 1'b1;
        else if (pp && sb_q.size() == 0) exp_irq = 1'b0;
        if (cl) exp_rsr = 4'h0;
        #1;
        push_valid = 0; push_break = 0; pop = 0; rsr_clr = 0;
        flags(tag, pv && !(pre < exp_depth));
    endtask

    task automatic set_mode(input logic en, input logic pv, input logic pp);
        @(negedge clk);
        fifo_en = en; push_valid = pv; push_data = 12'h0EE; pop = pp; in_flush = 1'b1;
        @(posedge clk);
        sb_q.delete();
        exp_depth = en ? 16 : 1;
        #1;
        push_valid = 0; pop = 0; in_flush = 1'b0;
        flags("R6 flush", 1'b0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        flags("R1 reset", 1'b0);

        // single-entry mode
        cyc(1, 0, 12'h3A5, 0, 0, "R2 first push");
        cyc(1, 0, 12'h111, 0, 0, "R2 drop when full");
        cyc(0, 0, 12'h000, 1, 0, "R5 pop single");
        chk("R7 rsr load", 32'(rsr), 32'h3);
        cyc(0, 0, 12'h000, 1, 0, "R5 pop empty");
        cyc(0, 0, 12'h000, 0, 1, "R7 clear");
        cyc(1, 0, 12'h9C3, 0, 0, "R7 push");
        cyc(0, 0, 12'h000, 1, 1, "R7 clear beats load");
        chk("R7 rsr after clear", 32'(rsr), 32'h0);

        // break entry
        cyc(1, 1, 12'hFFF, 0, 0, "R8 break push");
        cyc(0, 0, 12'h000, 1, 0, "R8 break pop");
        chk("R8 break status", 32'(rsr), 32'h4);

        // full single slot with simultaneous pop
        cyc(1, 0, 12'h155, 0, 0, "R10 fill");
        cyc(1, 0, 12'h266, 1, 0, "R10 full push+pop");

        // flush keeps irq, a pop on empty clears it
        cyc(1, 0, 12'h077, 0, 0, "R9 push");
        set_mode(1'b1, 1'b0, 1'b0);
        chk("R9 irq kept through flush", 32'(rx_irq), 32'h1);
        cyc(0, 0, 12'h000, 1, 0, "R9 empty pop clears");

        // queue mode: fill, overrun, drain with wrap
        for (int i = 0; i < 16; i++)
            cyc(1, 0, 12'(i * 37 + 5), 0, 0, "R3 fill");
        chk("R3 full at 16", 32'(full), 32'h1);
        cyc(1, 0, 12'hABC, 0, 0, "R4 overrun deep");
        for (int i = 0; i < 5; i++)
            cyc(0, 0, 12'h000, 1, 0, "R11 partial drain");
        for (int i = 0; i < 5; i++)
            cyc(1, 0, 12'(i * 91 + 300), 0, 0, "R11 refill wrap");
        for (int i = 0; i < 20; i++)
            cyc(1, 0, 12'(i * 13 + 7), 1, 0, "R10 push+pop deep");
        for (int i = 0; i < 16; i++)
            cyc(0, 0, 12'h000, 1, 0, "R11 drain");
        chk("R11 empty after wrap", 32'(empty), 32'h1);
        cyc(1, 0, 12'h812, 1, 0, "R10 push+pop empty");

        // mode change with traffic ignored
        cyc(1, 0, 12'h123, 0, 0, "R6 preload");
        set_mode(1'b0, 1'b1, 1'b1);
        cyc(0, 0, 12'h000, 0, 0, "R6 idle after flush");
        set_mode(1'b1, 1'b1, 1'b0);
        set_mode(1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule